// File: doc/BRIEF.md
# Label-Filtered Receive Interrupt Controller

This block turns word arrivals on eight receive channels into host interrupts. Each arriving word brings a channel number and an 8-bit label. A per-channel table of 256 enable bits, one for each label value, decides whether the word counts. On a hit, the channel's pending bit is set and its label register captures the label. A per-channel mask then decides whether the hit drives the interrupt output. That output stays high until the acknowledge input is seen high, and it is never shorter than a programmed minimum width. If acknowledge is tied high, each event therefore produces a fixed-width pulse.

Four fault flags come in through their own inputs. They stick until the host reads them, and they drive a second interrupt output that no mask can suppress. The host reaches the enable table, the mask, the pending bits, the fault flags and the captured labels through a flat byte-wide register port. Reads from that port are combinational.

Top module: `lbl_irq_ctrl`

## Requirements
- R1: A word counts as a hit only when the enable bit for its channel and label is 1. A word that misses leaves the pending bits, the label registers and the interrupt output unchanged.
- R2: A hit on channel n sets pending bit n and loads label register n with the label at the next clock edge. A later hit on the same channel overwrites that label.
- R3: The interrupt output rises only when some pending bit has its mask bit set. Setting a mask bit while that channel's bit is already pending raises the output.
- R4: While acknowledge is low, an asserted interrupt output stays high.
- R5: Once raised, the interrupt output stays high for at least PULSE_CYC cycles (default 250, about 1 us at 250 MHz). After that it drops at the first edge where acknowledge is high. With acknowledge held high, each event gives a pulse exactly PULSE_CYC cycles long. A masked-in hit that arrives while the output is high restarts the count.
- R6: A read of the pending register returns its current value and clears it to 0x00 at the same edge. A hit arriving in the same cycle as that read stays set.
- R7: A 1 on any of the four fault inputs sets the matching sticky flag, and the fault interrupt output is high while any flag is set. These flags have no mask. A read of the fault register returns the flags in bits 3:0 and clears them.
- R8: Register map on the 9-bit address, 8-bit data:
  - 0x000: mask (read/write, bit n is channel n).
  - 0x001: pending (read-clear).
  - 0x002: fault flags (read-clear).
  - 0x008+n: label register of channel n (read-only).
  - 0x100 + 32·ch + label/8: enable table byte, where bit label%8 enables that label.
  - Writes to the read-only addresses have no effect.
- R9: After reset, every register, every table bit and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_chan | input | 3 | Channel of the received word |
| rx_label | input | 8 | Label of the received word |
| flt_in | input | 4 | Fault event inputs, one per flag |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (triggers read-clear) |
| host_addr | input | 9 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational on address |
| ack_in | input | 1 | Interrupt acknowledge |
| irq_out | output | 1 | Receive interrupt |
| fault_irq | output | 1 | Fault interrupt |

## Verification
A wrong enable-table bit or address decode shows up at the first pending read after the word concerned, as a missing or extra bit. A stale label register shows up when the label is read back. Faults in the pulse timer show up in the count of high cycles on the interrupt output, which is exact when acknowledge is held high. Lost or leaked read-clear behaviour shows up at the very next read of the same register.

// File: rtl/lbl_irq_ctrl.sv
module lbl_irq_ctrl #(
  parameter int NCH       = 8,
  parameter int LW        = 8,
  parameter int NFLT      = 4,
  parameter int PULSE_CYC = 250,
  localparam int CW = $clog2(NCH),
  localparam int NLBL = 1 << LW,
  localparam int AW = $clog2(NCH * NLBL / 8) + 1,
  localparam int TW = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_chan,
  input  logic [LW-1:0] rx_label,
  input  logic [NFLT-1:0] flt_in,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          ack_in,
  output logic          irq_out,
  output logic          fault_irq
);
  logic [NCH*NLBL-1:0] en_q;
  logic [NCH-1:0]  mask_q, pend_q;
  logic [LW-1:0]   lbl_q [NCH];
  logic [NFLT-1:0] flt_q;
  logic            irq_q, cond_q;
  logic [TW-1:0]   tmr_q;

  wire            tbl_sel = host_addr[AW-1];
  wire [AW-2:0]   tb      = host_addr[AW-2:0];
  wire            hit     = rx_valid & en_q[{rx_chan, rx_label}];
  wire [NCH-1:0]  hit_vec = hit ? ({{(NCH-1){1'b0}}, 1'b1} << rx_chan) : '0;
  wire            rd_pend = host_re && host_addr == AW'(1);
  wire            rd_flt  = host_re && host_addr == AW'(2);
  wire            wr_mask = host_we && host_addr == AW'(0);
  wire [NCH-1:0]  mask_d  = wr_mask ? host_wdata[NCH-1:0] : mask_q;
  wire [NCH-1:0]  pend_d  = (rd_pend ? '0 : pend_q) | hit_vec;
  wire            cond_d  = |(pend_d & mask_d);
  wire            trig    = (cond_d & ~cond_q) | (|(hit_vec & mask_d));

  assign irq_out   = irq_q;
  assign fault_irq = |flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
      flt_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      if (host_we && tbl_sel) en_q[{tb, 3'b000} +: 8] <= host_wdata;
      mask_q <= mask_d;
      pend_q <= pend_d;
      flt_q  <= (rd_flt ? '0 : flt_q) | flt_in;
      cond_q <= cond_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lbl
    always_ff @(posedge clk) begin
      if (!rst_n) lbl_q[g] <= '0;
      else if (hit_vec[g]) lbl_q[g] <= rx_label;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      tmr_q <= '0;
    end else if (trig) begin
      irq_q <= 1'b1;
      tmr_q <= TW'(PULSE_CYC - 1);
    end else if (irq_q) begin
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      else if (ack_in) irq_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (tbl_sel) host_rdata = en_q[{tb, 3'b000} +: 8];
    else if (host_addr == AW'(0)) host_rdata[NCH-1:0] = mask_q;
    else if (host_addr == AW'(1)) host_rdata[NCH-1:0] = pend_q;
    else if (host_addr == AW'(2)) host_rdata[NFLT-1:0] = flt_q;
    else if (host_addr[AW-2:3] == (AW-4)'(1)) host_rdata[LW-1:0] = lbl_q[host_addr[CW-1:0]];
  end
endmodule

module lbl_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int NFLT = 4,
  parameter int AW = 9
) (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic ack_in,
  input logic irq_out,
  input logic fault_irq,
  input logic [NFLT-1:0] flt_in,
  input logic host_re,
  input logic [AW-1:0] host_addr,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] hit_vec
);
  a_r2_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec != '0 |=> (pend_q & $past(hit_vec)) == $past(hit_vec));
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (pend_q & mask_q) != '0);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !ack_in |=> irq_out);
  a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |=> irq_out);
  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    host_re && host_addr == AW'(1) && !rx_valid |=> pend_q == '0);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq && !(host_re && host_addr == AW'(2)) |=> fault_irq);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    flt_in != '0 |=> fault_irq);
endmodule

bind lbl_irq_ctrl lbl_irq_ctrl_chk #(.NCH(NCH), .NFLT(NFLT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ack_in(ack_in),
  .irq_out(irq_out), .fault_irq(fault_irq), .flt_in(flt_in),
  .host_re(host_re), .host_addr(host_addr), .pend_q(pend_q),
  .mask_q(mask_q), .hit_vec(hit_vec)
);

// File: tb/sim_lbl_irq_ctrl.sv
module sim_lbl_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [2:0] rx_chan = '0;
  logic [7:0] rx_label = '0;
  logic [3:0] flt_in = '0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [8:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata, rv;
  logic ack_in = 1'b0, irq_out, fault_irq;
  int checks = 0, failures = 0, n;

  always #2 clk = ~clk;

  lbl_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_chan(rx_chan),
    .rx_label(rx_label), .flt_in(flt_in), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ack_in(ack_in), .irq_out(irq_out), .fault_irq(fault_irq));

  // {channel, label, expect hit}
  localparam logic [11:0] VEC [8] = '{
    {3'd7, 8'hD4, 1'b1}, {3'd7, 8'hD5, 1'b0}, {3'd6, 8'hD4, 1'b0}, {3'd0, 8'h00, 1'b1},
    {3'd3, 8'hFF, 1'b1}, {3'd3, 8'hFE, 1'b0}, {3'd5, 8'h80, 1'b1}, {3'd5, 8'h88, 1'b0}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_re = 0;
  endtask

  task automatic send(logic [2:0] c, logic [7:0] l);
    @(negedge clk); rx_valid = 1; rx_chan = c; rx_label = l;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic enable(logic [2:0] c, logic [7:0] l);
    logic [7:0] cur;
    rd(9'h100 + {c, l[7:3]}, cur);
    cur[l[2:0]] = 1'b1;
    wr(9'h100 + {c, l[7:3]}, cur);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 irq", irq_out, 0);
    chk("R9 fault_irq", fault_irq, 0);
    rd(9'h001, rv); chk("R9 pending", rv, 0);
    rd(9'h000, rv); chk("R9 mask", rv, 0);
    rd(9'h1F4, rv); chk("R9 table", rv, 0);

    enable(7, 8'hD4); enable(0, 8'h00); enable(3, 8'hFF); enable(5, 8'h80);
    rd(9'h100 + {3'd7, 5'h1A}, rv); chk("R8 table byte", rv, 8'h10);

    // R1 R2 vector walk
    foreach (VEC[i]) begin
      send(VEC[i][11:9], VEC[i][8:1]);
      rd(9'h001, rv);
      chk("R1 R2 pending", rv, VEC[i][0] ? (8'h1 << VEC[i][11:9]) : 8'h0);
      if (VEC[i][0]) begin
        rd(9'h008 + VEC[i][11:9], rv);
        chk("R2 label", rv, VEC[i][8:1]);
      end
      chk("R3 irq masked off", irq_out, 0);
    end
    rd(9'h00D, rv); chk("R1 miss keeps label", rv, 8'h80);

    // R2 overwrite
    enable(7, 8'h11);
    send(7, 8'hD4); send(7, 8'h11);
    rd(9'h00F, rv); chk("R2 overwrite", rv, 8'h11);
    // R8 write to read-only label reg ignored
    wr(9'h00F, 8'h55);
    rd(9'h00F, rv); chk("R8 ro label", rv, 8'h11);

    // R6 read clears, simultaneous hit survives
    @(negedge clk); host_re = 1; host_addr = 9'h001;
    rx_valid = 1; rx_chan = 0; rx_label = 8'h00; #1 rv = host_rdata;
    @(negedge clk); host_re = 0; rx_valid = 0;
    chk("R6 read value", rv, 8'h80);
    rd(9'h001, rv); chk("R6 simultaneous hit kept", rv, 8'h01);
    rd(9'h001, rv); chk("R6 cleared", rv, 8'h00);

    // R3 mask write with pending raises irq
    send(7, 8'hD4);
    chk("R3 no irq unmasked", irq_out, 0);
    wr(9'h000, 8'h80);
    chk("R3 mask raises irq", irq_out, 1);
    // R4 hold while ack low
    repeat (300) @(negedge clk);
    chk("R4 hold", irq_out, 1);
    @(negedge clk); ack_in = 1;
    @(negedge clk);
    chk("R5 ack drops", irq_out, 0);

    // R5 pulse width with ack tied high
    rd(9'h001, rv);
    send(7, 8'hD4);
    n = 0;
    while (irq_out && n < 1000) begin n++; @(negedge clk); end
    chk("R5 pulse width", n, 250);

    // R5 retrigger
    send(7, 8'hD4);
    n = 0;
    while (irq_out && n < 1000) begin
      n++;
      if (n == 100) begin rx_valid = 1; rx_chan = 7; rx_label = 8'hD4; end
      else rx_valid = 0;
      @(negedge clk);
    end
    rx_valid = 0;
    chk("R5 retrigger width", n, 350);

    // R1 miss does not trigger irq
    rd(9'h001, rv);
    send(7, 8'hD6);
    chk("R1 miss no irq", irq_out, 0);
    ack_in = 0;

    // R7 faults
    @(negedge clk); flt_in = 4'b0101;
    @(negedge clk); flt_in = 0;
    chk("R7 fault irq", fault_irq, 1);
    wr(9'h000, 8'h00);
    repeat (5) @(negedge clk);
    chk("R7 sticky unmaskable", fault_irq, 1);
    rd(9'h002, rv); chk("R7 flags", rv, 8'h05);
    chk("R7 cleared irq", fault_irq, 0);
    rd(9'h002, rv); chk("R7 cleared flags", rv, 8'h00);

    finish_run();
  end
endmodule